// File: doc/BRIEF.md
# Depthwise Hadamard multiply-accumulator

This block keeps a bank of thirty-two 32-bit accumulators for depthwise convolution. Each operation supplies three activation rows and three weight rows, each 32 bytes wide, together with a sign choice and a signed 9-bit offset for each operand kind. In every byte lane the block widens both operand bytes, adds the offsets, multiplies, sums the three row products and adds that sum into one accumulator slot. Lanes are spread over the slots so that a group of four neighbouring lanes lands in four different output registers.

An operation either only accumulates, accumulates and then presents the whole bank as four 256-bit output registers, or replaces the bank with initialization data. A synchronous clear zeroes the bank. An operation flagged as having a failed operand gather is discarded. Choosing the operands, decoding the instruction and writing the register file are done elsewhere.

Top module: `dw_hadamard_mac`

## Requirements
- R1: Each operand byte is zero-extended when its sign input is 0 and sign-extended when it is 1, and then the two's complement 9-bit offset for that operand kind is added before the multiply.
- R2: For row k (bits [k*256 + 8*i +: 8] of each row bus) and lane i in 0..31, the product is added to accumulator slot 8*T[i mod 4] + (i div 4) with T = {0, 2, 1, 3}; all three rows contribute in one operation.
- R3: Slots are 32 bits wide and sums wrap modulo 2^32 as two's complement.
- R4: Operation code 0 (accumulate) updates the bank and never raises res_valid_o.
- R5: Operation code 1 (accumulate and emit) raises res_valid_o for one cycle two clock edges after the operation is sampled, with the updated bank on res_data_o: register r word j, at bits [256*r + 32*j +: 32], is slot 8*r + j.
- R6: Operation code 2 (load) copies init_data_i into the bank: byte 4*m+n of source register k (bits [256*k + 8*(4*m+n) +: 8]) becomes byte n of slot 8*k+m; it raises no res_valid_o.
- R7: clr_i zeroes every slot at the edge where it is sampled, discards an operation sampled at the same edge and cancels an operation accepted one edge earlier, including its output.
- R8: An operation with op_err_i set leaves the bank unchanged and raises no res_valid_o.
- R9: Operation code 3 is reserved; it leaves the bank unchanged and raises no res_valid_o.
- R10: A new operation may be sampled at every edge; consecutive operations each add their full contribution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, zeroes bank and pipeline |
| clr_i | input | 1 | Synchronous clear of the bank |
| op_valid_i | input | 1 | An operation is presented this cycle |
| op_kind_i | input | 2 | 0 accumulate, 1 accumulate and emit, 2 load, 3 reserved |
| op_err_i | input | 1 | Operand gather failed; discard the operation |
| act_rows_i | input | 768 | Three activation rows, row k at bits [256*k +: 256] |
| wgt_rows_i | input | 768 | Three weight rows, row k at bits [256*k +: 256] |
| act_signed_i | input | 1 | Activation bytes are signed |
| act_bias_i | input | 9 | Signed offset added to each activation |
| wgt_signed_i | input | 1 | Weight bytes are signed |
| wgt_bias_i | input | 9 | Signed offset added to each weight |
| init_data_i | input | 1024 | Four source registers for the load operation |
| res_valid_o | output | 1 | Emitted registers are valid |
| res_data_o | output | 1024 | Bank contents as four 256-bit registers |

## Verification
An operation sampled at edge E0 has its lane sums registered at E0 and reaches the bank at E1, so both the new bank contents and res_valid_o are due in the cycle between E1 and E2. The directed tasks drive inputs at a falling edge and sample at the falling edge after E1, where they compare res_valid_o and all thirty-two slots against a bench model updated as each operation is issued. Operations that must have no effect are checked by emitting a zero-product operation afterwards and comparing the bank, and cancellation by clear is checked at the exact falling edge where the output would otherwise have appeared.

// File: rtl/dwm_pkg.sv
package dwm_pkg;

    typedef enum logic [1:0] {
        OPK_ACCUM = 2'd0,
        OPK_EMIT  = 2'd1,
        OPK_LOAD  = 2'd2,
        OPK_RSVD  = 2'd3
    } opk_e;

    // Exchange the two low bits of a quarter index: 0,1,2,3 -> 0,2,1,3.
    function automatic int unsigned quarter_swap(input int unsigned q);
        return ((q & 1) << 1) | ((q >> 1) & 1);
    endfunction

    // Slot that a lane accumulates into.
    function automatic int unsigned slot_of_lane(input int unsigned lane,
                                                 input int unsigned words_per_reg);
        return words_per_reg * quarter_swap(lane % 4) + lane / 4;
    endfunction

    // Lane feeding a given slot (inverse of slot_of_lane).
    function automatic int unsigned lane_of_slot(input int unsigned slot,
                                                 input int unsigned words_per_reg);
        return (slot % words_per_reg) * 4 + quarter_swap(slot / words_per_reg);
    endfunction

endpackage

// File: rtl/dwm_operand.sv
module dwm_operand #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned BIAS_W = 9,
    parameter int unsigned OPW    = 10
) (
    input  logic [BYTE_W-1:0]     byte_i,
    input  logic                  sgn_i,
    input  logic [BIAS_W-1:0]     bias_i,
    output logic signed [OPW-1:0] val_o
);

    logic signed [OPW-1:0] ext;
    logic signed [OPW-1:0] off;

    always_comb begin
        if (sgn_i) begin
            ext = {{(OPW-BYTE_W){byte_i[BYTE_W-1]}}, byte_i};
        end else begin
            ext = {{(OPW-BYTE_W){1'b0}}, byte_i};
        end
        off   = {{(OPW-BIAS_W){bias_i[BIAS_W-1]}}, bias_i};
        val_o = ext + off;
    end

endmodule

// File: rtl/dwm_lane.sv
module dwm_lane #(
    parameter int unsigned ROWS   = 3,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned BIAS_W = 9,
    parameter int unsigned OPW    = 10,
    parameter int unsigned SUMW   = 23
) (
    input  logic [ROWS*BYTE_W-1:0] act_i,
    input  logic [ROWS*BYTE_W-1:0] wgt_i,
    input  logic                   act_sgn_i,
    input  logic [BIAS_W-1:0]      act_bias_i,
    input  logic                   wgt_sgn_i,
    input  logic [BIAS_W-1:0]      wgt_bias_i,
    output logic signed [SUMW-1:0] sum_o
);

    localparam int unsigned PRODW = 2 * OPW;

    logic signed [OPW-1:0]   a_val [ROWS];
    logic signed [OPW-1:0]   w_val [ROWS];
    logic signed [PRODW-1:0] prod  [ROWS];

    for (genvar k = 0; k < ROWS; k++) begin : g_row
        dwm_operand #(.BYTE_W(BYTE_W), .BIAS_W(BIAS_W), .OPW(OPW)) act_op_i (
            .byte_i (act_i[k*BYTE_W +: BYTE_W]),
            .sgn_i  (act_sgn_i),
            .bias_i (act_bias_i),
            .val_o  (a_val[k])
        );
        dwm_operand #(.BYTE_W(BYTE_W), .BIAS_W(BIAS_W), .OPW(OPW)) wgt_op_i (
            .byte_i (wgt_i[k*BYTE_W +: BYTE_W]),
            .sgn_i  (wgt_sgn_i),
            .bias_i (wgt_bias_i),
            .val_o  (w_val[k])
        );
        assign prod[k] = PRODW'(a_val[k]) * PRODW'(w_val[k]);
    end

    always_comb begin
        sum_o = '0;
        for (int k = 0; k < ROWS; k++) begin
            sum_o = sum_o + SUMW'(prod[k]);
        end
    end

endmodule

// File: rtl/dwm_acc_bank.sv
module dwm_acc_bank #(
    parameter int unsigned ENTRIES = 32,
    parameter int unsigned ACC_W   = 32,
    parameter int unsigned ADD_W   = 23
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     add_en_i,
    input  logic [ENTRIES*ADD_W-1:0] add_vals_i,
    input  logic                     load_en_i,
    input  logic [ENTRIES*ACC_W-1:0] load_vals_i,
    output logic [ENTRIES*ACC_W-1:0] acc_o
);

    typedef struct packed {
        logic [ENTRIES-1:0][ACC_W-1:0] slot;
    } bank_t;

    bank_t bank_d;
    bank_t bank_q;

    always_comb begin
        logic [ADD_W-1:0] inc;
        bank_d = bank_q;
        inc    = '0;
        if (clr_i) begin
            bank_d.slot = '0;
        end else if (load_en_i) begin
            for (int e = 0; e < ENTRIES; e++) begin
                bank_d.slot[e] = load_vals_i[e*ACC_W +: ACC_W];
            end
        end else if (add_en_i) begin
            for (int e = 0; e < ENTRIES; e++) begin
                inc = add_vals_i[e*ADD_W +: ADD_W];
                bank_d.slot[e] = bank_q.slot[e]
                               + {{(ACC_W-ADD_W){inc[ADD_W-1]}}, inc};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign acc_o = bank_q.slot;

endmodule

// File: rtl/dw_hadamard_mac.sv
module dw_hadamard_mac
    import dwm_pkg::*;
#(
    parameter int unsigned LANES    = 32,
    parameter int unsigned ROWS     = 3,
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned BIAS_W   = 9,
    parameter int unsigned ACC_W    = 32,
    parameter int unsigned OUT_REGS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr_i,
    input  logic                         op_valid_i,
    input  logic [1:0]                   op_kind_i,
    input  logic                         op_err_i,
    input  logic [ROWS*LANES*BYTE_W-1:0] act_rows_i,
    input  logic [ROWS*LANES*BYTE_W-1:0] wgt_rows_i,
    input  logic                         act_signed_i,
    input  logic [BIAS_W-1:0]            act_bias_i,
    input  logic                         wgt_signed_i,
    input  logic [BIAS_W-1:0]            wgt_bias_i,
    input  logic [LANES*ACC_W-1:0]       init_data_i,
    output logic                         res_valid_o,
    output logic [LANES*ACC_W-1:0]       res_data_o
);

    // Derived sizes
    localparam int unsigned WPR      = LANES / OUT_REGS;
    localparam int unsigned ROW_BITS = LANES * BYTE_W;
    localparam int unsigned ACC_BITS = LANES * ACC_W;
    localparam int unsigned EXT_W    = (BYTE_W + 1 > BIAS_W) ? BYTE_W + 1 : BIAS_W;
    localparam int unsigned OPW      = EXT_W + 1;
    localparam int unsigned SUMW     = 2 * OPW + $clog2(ROWS) + 1;

    typedef struct packed {
        logic                    s1_vld;
        opk_e                    s1_kind;
        logic [LANES*SUMW-1:0]   s1_sums;
        logic [ACC_BITS-1:0]     s1_load;
        logic                    emit_vld;
    } pipe_t;

    pipe_t pipe_d;
    pipe_t pipe_q;

    logic [LANES*SUMW-1:0] lane_sum;
    logic [LANES*SUMW-1:0] slot_add;
    logic                  accept;
    logic                  add_en;
    logic                  load_en;
    logic                  s1_live;

    // Per-lane products, three rows summed
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [ROWS*BYTE_W-1:0] a_l;
        logic [ROWS*BYTE_W-1:0] w_l;
        for (genvar k = 0; k < ROWS; k++) begin : g_pick
            assign a_l[k*BYTE_W +: BYTE_W] = act_rows_i[k*ROW_BITS + i*BYTE_W +: BYTE_W];
            assign w_l[k*BYTE_W +: BYTE_W] = wgt_rows_i[k*ROW_BITS + i*BYTE_W +: BYTE_W];
        end
        dwm_lane #(
            .ROWS(ROWS), .BYTE_W(BYTE_W), .BIAS_W(BIAS_W), .OPW(OPW), .SUMW(SUMW)
        ) lane_i (
            .act_i      (a_l),
            .wgt_i      (w_l),
            .act_sgn_i  (act_signed_i),
            .act_bias_i (act_bias_i),
            .wgt_sgn_i  (wgt_signed_i),
            .wgt_bias_i (wgt_bias_i),
            .sum_o      (lane_sum[i*SUMW +: SUMW])
        );
    end

    // Interleave: registered lane sums routed to their slots by wiring
    for (genvar e = 0; e < LANES; e++) begin : g_slot
        localparam int unsigned SRC = lane_of_slot(e, WPR);
        assign slot_add[e*SUMW +: SUMW] = pipe_q.s1_sums[SRC*SUMW +: SUMW];
    end

    always_comb begin
        pipe_d = pipe_q;
        accept = op_valid_i && !op_err_i && (opk_e'(op_kind_i) != OPK_RSVD);

        pipe_d.s1_vld  = accept && !clr_i;
        pipe_d.s1_kind = opk_e'(op_kind_i);
        if (accept) begin
            pipe_d.s1_sums = lane_sum;
            pipe_d.s1_load = init_data_i;
        end
        pipe_d.emit_vld = pipe_q.s1_vld && (pipe_q.s1_kind == OPK_EMIT) && !clr_i;

        add_en  = pipe_q.s1_vld && (pipe_q.s1_kind != OPK_LOAD);
        load_en = pipe_q.s1_vld && (pipe_q.s1_kind == OPK_LOAD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    dwm_acc_bank #(.ENTRIES(LANES), .ACC_W(ACC_W), .ADD_W(SUMW)) bank_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_i),
        .add_en_i    (add_en),
        .add_vals_i  (slot_add),
        .load_en_i   (load_en),
        .load_vals_i (pipe_q.s1_load),
        .acc_o       (res_data_o)
    );

    assign s1_live     = pipe_q.s1_vld;
    assign res_valid_o = pipe_q.emit_vld;

endmodule

// File: rtl/dwm_checker.sv
module dwm_checker
    import dwm_pkg::*;
#(
    parameter int unsigned ACC_BITS = 1024
) (
    input logic                clk,
    input logic                rst_n,
    input logic                clr_i,
    input logic                op_valid_i,
    input logic [1:0]          op_kind_i,
    input logic                op_err_i,
    input logic [ACC_BITS-1:0] init_data_i,
    input logic                s1_live,
    input logic                res_valid_o,
    input logic [ACC_BITS-1:0] res_data_o
);

    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (res_data_o == '0) && !res_valid_o);

    p_emit_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> ($past(op_valid_i, 2) && ($past(op_kind_i, 2) == OPK_EMIT)
                         && !$past(op_err_i, 2) && !$past(clr_i, 2) && !$past(clr_i, 1)));

    p_accum_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_valid_i, 2) && ($past(op_kind_i, 2) != OPK_EMIT)) |-> !res_valid_o);

    p_load_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_valid_i, 2) && ($past(op_kind_i, 2) == OPK_LOAD) && !$past(op_err_i, 2)
         && !$past(clr_i, 2) && !$past(clr_i, 1)) |-> (res_data_o == $past(init_data_i, 2)));

    // Covers R8 and R9: a discarded operation never reaches the bank
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!s1_live && !clr_i) |=> $stable(res_data_o));

endmodule

bind dw_hadamard_mac dwm_checker #(.ACC_BITS(LANES*ACC_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_i),
    .op_valid_i  (op_valid_i),
    .op_kind_i   (op_kind_i),
    .op_err_i    (op_err_i),
    .init_data_i (init_data_i),
    .s1_live     (s1_live),
    .res_valid_o (res_valid_o),
    .res_data_o  (res_data_o)
);

// File: tb/dw_hadamard_mac_tb_top.sv
module dw_hadamard_mac_tb_top;

    localparam int LANES    = 32;
    localparam int ROWS     = 3;
    localparam int ROW_BITS = LANES * 8;
    localparam int ACC_BITS = LANES * 32;
    localparam logic [1:0] K_ACC  = 2'd0;
    localparam logic [1:0] K_EMIT = 2'd1;
    localparam logic [1:0] K_LOAD = 2'd2;
    localparam logic [1:0] K_RSVD = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic op_valid = 1'b0;
    logic [1:0] op_kind = 2'd0;
    logic op_err = 1'b0;
    logic [ROWS*ROW_BITS-1:0] act_v = '0;
    logic [ROWS*ROW_BITS-1:0] wgt_v = '0;
    logic act_sg = 1'b0;
    logic wgt_sg = 1'b0;
    logic [8:0] act_b = 9'd0;
    logic [8:0] wgt_b = 9'd0;
    logic [ACC_BITS-1:0] init_v = '0;
    logic res_valid;
    logic [ACC_BITS-1:0] res_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int acc_m [LANES];
    int slot_tbl [4] = '{0, 2, 1, 3};

    always #4 clk = ~clk;

    dw_hadamard_mac dut_i (
        .clk (clk), .rst_n (rst_n), .clr_i (clr),
        .op_valid_i (op_valid), .op_kind_i (op_kind), .op_err_i (op_err),
        .act_rows_i (act_v), .wgt_rows_i (wgt_v),
        .act_signed_i (act_sg), .act_bias_i (act_b),
        .wgt_signed_i (wgt_sg), .wgt_bias_i (wgt_b),
        .init_data_i (init_v),
        .res_valid_o (res_valid), .res_data_o (res_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] e);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, a, e);
        end
    endtask

    function automatic int adj(input logic [7:0] b, input logic sg, input logic [8:0] bias);
        int v;
        v = sg ? int'($signed(b)) : int'({24'd0, b});
        return v + int'($signed(bias));
    endfunction

    task automatic model_zero();
        for (int e = 0; e < LANES; e++) acc_m[e] = 0;
    endtask

    task automatic model_step(input logic [1:0] kind);
        if (kind == K_LOAD) begin
            for (int k = 0; k < 4; k++) begin
                for (int m = 0; m < 8; m++) begin
                    logic [31:0] w;
                    for (int n = 0; n < 4; n++) begin
                        w[n*8 +: 8] = init_v[k*ROW_BITS + (4*m+n)*8 +: 8];
                    end
                    acc_m[8*k+m] = int'(w);
                end
            end
        end else begin
            for (int k = 0; k < ROWS; k++) begin
                for (int i = 0; i < LANES; i++) begin
                    int a;
                    int w;
                    a = adj(act_v[k*ROW_BITS + i*8 +: 8], act_sg, act_b);
                    w = adj(wgt_v[k*ROW_BITS + i*8 +: 8], wgt_sg, wgt_b);
                    acc_m[8*slot_tbl[i%4] + i/4] += a * w;
                end
            end
        end
    endtask

    // Present one operation at a falling edge; returns at the next falling edge
    task automatic issue(input logic [1:0] kind, input bit err, input bit c);
        op_kind  = kind;
        op_err   = err;
        clr      = c;
        op_valid = 1'b1;
        if (c) model_zero();
        else if (!err && kind != K_RSVD) model_step(kind);
        @(negedge clk);
        op_valid = 1'b0;
        op_err   = 1'b0;
        clr      = 1'b0;
    endtask

    task automatic pulse_clear();
        clr = 1'b1;
        model_zero();
        @(negedge clk);
        clr = 1'b0;
    endtask

    function automatic logic [31:0] word_at(input int r, input int j);
        return res_data[r*256 + j*32 +: 32];
    endfunction

    task automatic check_regs(input string tag);
        int bad;
        logic [31:0] ga;
        logic [31:0] ge;
        bad = 0;
        ga = '0;
        ge = '0;
        for (int r = 0; r < 4; r++) begin
            for (int j = 0; j < 8; j++) begin
                if (word_at(r, j) !== 32'(acc_m[8*r+j]) && bad == 0) begin
                    bad = 1;
                    ga = word_at(r, j);
                    ge = 32'(acc_m[8*r+j]);
                end
            end
        end
        chk(bad == 0, tag, {32'd0, ga}, {32'd0, ge});
    endtask

    task automatic expect_emit(input string tag);
        @(negedge clk);
        chk(res_valid === 1'b1, {tag, " valid"}, {63'd0, res_valid}, 64'd1);
        check_regs({tag, " data"});
    endtask

    task automatic expect_quiet(input string tag);
        @(negedge clk);
        chk(res_valid === 1'b0, {tag, " no output"}, {63'd0, res_valid}, 64'd0);
    endtask

    task automatic zero_ops();
        act_v = '0; wgt_v = '0;
        act_sg = 1'b0; wgt_sg = 1'b0;
        act_b = 9'd0; wgt_b = 9'd0;
    endtask

    task automatic emit_zero(input string tag);
        zero_ops();
        issue(K_EMIT, 1'b0, 1'b0);
        expect_emit(tag);
    endtask

    task automatic rand_ops();
        for (int w = 0; w < ROWS*ROW_BITS/32; w++) begin
            act_v[w*32 +: 32] = $urandom;
            wgt_v[w*32 +: 32] = $urandom;
        end
        act_sg = 1'($urandom);
        wgt_sg = 1'($urandom);
        act_b  = 9'($urandom);
        wgt_b  = 9'($urandom);
    endtask

    // ---------------- scenarios ----------------

    task automatic t_reset();
        chk(res_valid === 1'b0, "reset R5 valid low", {63'd0, res_valid}, 64'd0);
        chk(res_data === '0, "reset R7 bank zero", res_data[63:0], 64'd0);
    endtask

    task automatic t_lane_map();
        pulse_clear();
        zero_ops();
        for (int i = 0; i < LANES; i++) begin
            act_v[i*8 +: 8] = 8'(i + 1);
            wgt_v[i*8 +: 8] = 8'd1;
        end
        issue(K_EMIT, 1'b0, 1'b0);
        expect_emit("R2 lane map");
        chk(word_at(1, 0) == 32'd3, "R2 slot 8 from lane 2", {32'd0, word_at(1, 0)}, 64'd3);
        chk(word_at(0, 1) == 32'd5, "R2 slot 1 from lane 4", {32'd0, word_at(0, 1)}, 64'd5);
        chk(word_at(3, 7) == 32'd32, "R2 slot 31 from lane 31", {32'd0, word_at(3, 7)}, 64'd32);
    endtask

    task automatic t_sign_bias();
        pulse_clear();
        for (int b = 0; b < ROWS*LANES; b++) begin
            act_v[b*8 +: 8] = 8'hFF;
            wgt_v[b*8 +: 8] = 8'h80;
        end
        act_sg = 1'b1; wgt_sg = 1'b1;
        act_b = 9'd2; wgt_b = 9'h1FF;
        issue(K_EMIT, 1'b0, 1'b0);
        expect_emit("R1 signed");
        chk(word_at(0, 0) == 32'hFFFF_FE7D, "R1 signed slot0 -387", {32'd0, word_at(0, 0)}, 64'hFFFF_FE7D);
        pulse_clear();
        act_sg = 1'b0; wgt_sg = 1'b0;
        issue(K_EMIT, 1'b0, 1'b0);
        expect_emit("R1 unsigned");
        chk(word_at(2, 5) == 32'd97917, "R1 unsigned slot 21", {32'd0, word_at(2, 5)}, 64'd97917);
    endtask

    task automatic t_random();
        for (int n = 0; n < 4; n++) begin
            rand_ops();
            issue(K_EMIT, 1'b0, 1'b0);
            expect_emit("R1 R2 random operands");
        end
    endtask

    task automatic t_accum_only();
        rand_ops();
        issue(K_ACC, 1'b0, 1'b0);
        expect_quiet("R4 accumulate");
        emit_zero("R4 accumulate reached bank");
    endtask

    task automatic t_load_wrap();
        for (int e = 0; e < LANES; e++) init_v[e*32 +: 32] = 32'h7FFF_FFFF;
        issue(K_LOAD, 1'b0, 1'b0);
        expect_quiet("R6 load");
        zero_ops();
        for (int b = 0; b < ROWS*LANES; b++) begin
            act_v[b*8 +: 8] = 8'd1;
            wgt_v[b*8 +: 8] = 8'd1;
        end
        issue(K_EMIT, 1'b0, 1'b0);
        expect_emit("R3 wrap");
        chk(word_at(0, 0) == 32'h8000_0002, "R3 wrap slot0", {32'd0, word_at(0, 0)}, 64'h8000_0002);
        for (int w = 0; w < ACC_BITS/32; w++) init_v[w*32 +: 32] = $urandom;
        issue(K_LOAD, 1'b0, 1'b0);
        expect_quiet("R6 load random");
        emit_zero("R6 loaded bytes");
    endtask

    task automatic t_clear();
        rand_ops();
        issue(K_ACC, 1'b0, 1'b0);
        pulse_clear();
        emit_zero("R7 clear cancels in-flight accumulate");
        rand_ops();
        issue(K_EMIT, 1'b0, 1'b1);
        expect_quiet("R7 op with clear");
        emit_zero("R7 op with clear discarded");
        rand_ops();
        issue(K_ACC, 1'b0, 1'b0);
        issue(K_EMIT, 1'b0, 1'b0);
        pulse_clear();
        chk(res_valid === 1'b0, "R7 clear cancels emit", {63'd0, res_valid}, 64'd0);
        emit_zero("R7 bank zero after clear");
    endtask

    task automatic t_discard();
        rand_ops();
        issue(K_ACC, 1'b0, 1'b0);
        @(negedge clk);
        rand_ops();
        issue(K_EMIT, 1'b1, 1'b0);
        expect_quiet("R8 error op");
        emit_zero("R8 bank unchanged");
        rand_ops();
        issue(K_RSVD, 1'b0, 1'b0);
        expect_quiet("R9 reserved code");
        emit_zero("R9 bank unchanged");
    endtask

    task automatic t_back_to_back();
        rand_ops();
        issue(K_ACC, 1'b0, 1'b0);
        rand_ops();
        issue(K_ACC, 1'b0, 1'b0);
        rand_ops();
        issue(K_EMIT, 1'b0, 1'b0);
        expect_emit("R10 back-to-back");
        chk(res_valid === 1'b1, "R10 single cycle valid", {63'd0, res_valid}, 64'd1);
        @(negedge clk);
        chk(res_valid === 1'b0, "R10 valid drops", {63'd0, res_valid}, 64'd0);
    endtask

    initial begin
        model_zero();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lane_map();
        t_sign_bias();
        t_random();
        t_accum_only();
        t_load_wrap();
        t_clear();
        t_discard();
        t_back_to_back();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule